// File: doc/BRIEF.md
# Four-slot pulse-position modem

This block carries a byte stream over an optical link at four chips per symbol. Each pair of data bits becomes one symbol: a single lit chip among four, and the index of that chip is the bit-pair value. The transmit half takes bytes through a valid/ready handshake and drives one line that changes only on a chip-rate enable. The receive half samples the detected light on the same enable, decides where symbol boundaries lie, decodes each four-chip window back to a bit pair, and packs bit pairs into bytes once it has locked.

Both halves run in the system clock domain. A one-cycle `chip_en` strobe marks each chip instant. The receiver accepts a pulse widened into the next chip of the same symbol. It flags empty, crowded or split windows as errors, and a coarse lock counter decides whether boundaries are trusted. Frame delimiting, checksums and the optical front end sit outside the block.

Top module: `ppm4_modem`

## Requirements
- R1: Transmit line updates and receive samples happen only at clock edges where `chip_en` is 1; the receiver ignores `rx_sample` values between chip edges.
- R2: A symbol is four chips, sent chip 0 first, with exactly one lit chip whose index equals the bit pair (00 lights chip 0, 01 chip 1, 10 chip 2, 11 chip 3).
- R3: A byte is sent as four symbols, bits 1:0 first and bits 7:6 last, so a byte takes 16 chips.
- R4: `tx_ready` is 1 while the transmitter is idle, and while busy it is 1 only in the cycle whose chip edge emits the final chip of a byte; a byte accepted there follows with no idle chip between. When no byte is in progress, the line stays 0.
- R5: A receive window with one lit chip decodes to that chip's index; two lit chips in adjacent positions decode to the earlier index.
- R6: A window with no lit chip, three or more, or two that are not adjacent is invalid. While locked, each invalid window gives a one-cycle `rx_err` pulse and adds no bit pair to the byte in progress; while unlocked, `rx_err` stays 0.
- R7: After reset the receiver is unlocked; `rx_lock` rises at the chip edge ending the fourth consecutive valid window.
- R8: While locked, two consecutive invalid windows drop `rx_lock`; a single invalid window followed by a valid one keeps it.
- R9: While unlocked, an invalid window makes the next window one chip shorter, so the boundary slips one chip earlier.
- R10: After lock, each group of four valid windows after the window that completed lock forms a byte (first window in bits 1:0), presented with a one-cycle `rx_data_valid` pulse; a partial byte is discarded when lock drops.
- R11: During reset `tx_line`, `rx_lock`, `rx_err` and `rx_data_valid` are 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | One-cycle strobe marking each chip instant |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter takes the byte at this edge |
| tx_line | output | 1 | Chip-rate optical drive line |
| rx_sample | input | 1 | Detected light level |
| rx_data | output | 8 | Last recovered byte |
| rx_data_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| rx_lock | output | 1 | Symbol boundary is trusted |
| rx_err | output | 1 | One-cycle strobe for an invalid window while locked |

## Verification
A wrong transmit shift or chip counter shows up at the first chip edge after a byte is accepted, as a lit chip at the wrong index or a missing or extra chip between back-to-back bytes. A receiver slot counter that is off by one shows up within one symbol, as a shifted bit pair or a lock that rises on the wrong window. A wrong hit or miss count shows up as lock moving one window early or late. A packer that does not clear on lock loss shows up as a corrupted first byte after relock.

// File: rtl/ppm4_pkg.sv
package ppm4_pkg;

  localparam int CHIPS = 4;

  typedef logic [1:0]       dibit_t;
  typedef logic [CHIPS-1:0] win_t;

  typedef struct packed {
    logic   ok;
    dibit_t sym;
  } dec_t;

  // Whether chip index c is lit for bit pair d.
  function automatic logic chip_lit(dibit_t d, logic [1:0] c);
    return d == c;
  endfunction

  // Classify a four-chip window (bit i = chip i).
  function automatic dec_t decode_win(win_t w);
    dec_t   r;
    int     n;
    dibit_t first;
    n     = 0;
    first = '0;
    for (int i = CHIPS - 1; i >= 0; i--) begin
      if (w[i]) begin
        n++;
        first = i[1:0];
      end
    end
    r.sym = first;
    r.ok  = (n == 1) || ((n == 2) && ((w & (w >> 1)) != '0));
    return r;
  endfunction

endpackage

// File: rtl/ppm4_tx.sv
module ppm4_tx
  import ppm4_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic [DATA_W-1:0] data,
  input  logic              valid,
  output logic              ready,
  output logic              line
);

  localparam int SYMS = DATA_W / 2;
  localparam int SW   = (SYMS > 1) ? $clog2(SYMS) : 1;

  logic              busy;
  logic [DATA_W-1:0] sh;
  logic [1:0]        chip;
  logic [SW-1:0]     symc;

  logic last_sym;
  logic last_chip;
  logic load;

  assign last_sym  = (symc == SW'(SYMS - 1));
  assign last_chip = busy && (chip == 2'd3) && last_sym;
  assign ready     = !busy || (chip_en && last_chip);
  assign load      = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '0;
      chip <= '0;
      symc <= '0;
      line <= 1'b0;
    end else begin
      if (chip_en) begin
        line <= busy && chip_lit(sh[1:0], chip);
        if (busy) begin
          chip <= chip + 2'd1;
          if (chip == 2'd3) begin
            sh   <= sh >> 2;
            symc <= symc + 1'b1;
            if (last_sym) busy <= 1'b0;
          end
        end
      end
      if (load) begin
        sh   <= data;
        busy <= 1'b1;
        chip <= '0;
        symc <= '0;
      end
    end
  end

endmodule

// File: rtl/ppm4_rx_sync.sv
module ppm4_rx_sync
  import ppm4_pkg::*;
#(
  parameter int LOCK_RUN = 4,
  parameter int LOSS_RUN = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   chip_en,
  input  logic   sample,
  output logic   eval,
  output logic   ok,
  output logic   locked,
  output logic   stb,
  output dibit_t sym,
  output logic   err
);

  localparam int HW = $clog2(LOCK_RUN + 1);
  localparam int MW = $clog2(LOSS_RUN + 1);

  logic [1:0]    slot;
  logic [2:0]    hist;
  logic [HW-1:0] hits;
  logic [MW-1:0] miss;
  win_t          nwin;
  dec_t          dec;
  logic          hit_full;
  logic          miss_full;

  assign nwin      = {sample, hist};
  assign dec       = decode_win(nwin);
  assign eval      = chip_en && (slot == 2'd3);
  assign ok        = dec.ok;
  assign hit_full  = (hits == HW'(LOCK_RUN - 1));
  assign miss_full = (miss == MW'(LOSS_RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= '0;
      hist   <= '0;
      hits   <= '0;
      miss   <= '0;
      locked <= 1'b0;
      stb    <= 1'b0;
      sym    <= '0;
      err    <= 1'b0;
    end else begin
      stb <= 1'b0;
      err <= 1'b0;
      if (chip_en) begin
        hist <= nwin[3:1];
        slot <= slot + 2'd1;
        if (eval) begin
          slot <= 2'd0;
          if (locked) begin
            if (dec.ok) begin
              miss <= '0;
              stb  <= 1'b1;
              sym  <= dec.sym;
            end else begin
              err <= 1'b1;
              if (miss_full) begin
                locked <= 1'b0;
                miss   <= '0;
              end else begin
                miss <= miss + 1'b1;
              end
            end
          end else begin
            if (dec.ok) begin
              if (hit_full) begin
                locked <= 1'b1;
                hits   <= '0;
                miss   <= '0;
              end else begin
                hits <= hits + 1'b1;
              end
            end else begin
              hits <= '0;
              slot <= 2'd1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/ppm4_rx_pack.sv
module ppm4_rx_pack
  import ppm4_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              stb,
  input  dibit_t            sym,
  output logic [DATA_W-1:0] data,
  output logic              valid
);

  localparam int SYMS = DATA_W / 2;
  localparam int CW   = (SYMS > 1) ? $clog2(SYMS) : 1;

  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] nxt;
  logic [CW-1:0]     cnt;

  assign nxt = {sym, shreg[DATA_W-1:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (clear) begin
        cnt <= '0;
      end else if (stb) begin
        shreg <= nxt;
        if (cnt == CW'(SYMS - 1)) begin
          cnt   <= '0;
          data  <= nxt;
          valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ppm4_modem.sv
module ppm4_modem
  import ppm4_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LOCK_RUN = 4,
  parameter int LOSS_RUN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_line,
  input  logic              rx_sample,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_data_valid,
  output logic              rx_lock,
  output logic              rx_err
);

  // Named internal events, observed by the bound checker.
  logic   rx_eval;
  logic   rx_sym_ok;
  logic   rx_stb;
  dibit_t rx_sym;

  ppm4_tx #(.DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .chip_en (chip_en),
    .data    (tx_data),
    .valid   (tx_valid),
    .ready   (tx_ready),
    .line    (tx_line)
  );

  ppm4_rx_sync #(.LOCK_RUN(LOCK_RUN), .LOSS_RUN(LOSS_RUN)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .chip_en (chip_en),
    .sample  (rx_sample),
    .eval    (rx_eval),
    .ok      (rx_sym_ok),
    .locked  (rx_lock),
    .stb     (rx_stb),
    .sym     (rx_sym),
    .err     (rx_err)
  );

  ppm4_rx_pack #(.DATA_W(DATA_W)) u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!rx_lock),
    .stb   (rx_stb),
    .sym   (rx_sym),
    .data  (rx_data),
    .valid (rx_data_valid)
  );

endmodule

// File: rtl/ppm4_modem_chk.sv
module ppm4_modem_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_en,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_line,
  input logic rx_lock,
  input logic rx_err,
  input logic rx_data_valid,
  input logic rx_eval,
  input logic rx_sym_ok
);

  p_line_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> $stable(tx_line));

  p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_err_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> $past(rx_lock));

  p_lock_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_lock) |-> $past(rx_eval && rx_sym_ok));

  p_lock_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_lock) |-> $past(rx_eval && !rx_sym_ok));

  p_byte_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_data_valid |-> $past(rx_lock));

endmodule

bind ppm4_modem ppm4_modem_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .chip_en       (chip_en),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_line       (tx_line),
  .rx_lock       (rx_lock),
  .rx_err        (rx_err),
  .rx_data_valid (rx_data_valid),
  .rx_eval       (rx_eval),
  .rx_sym_ok     (rx_sym_ok)
);

// File: tb/ppm4_modem_test.sv
module ppm4_modem_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_en = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       rx_sample = 1'b0;
  logic       tx_ready, tx_line;
  logic [7:0] rx_data;
  logic       rx_data_valid, rx_lock, rx_err;

  int checks = 0;
  int failures = 0;
  bit ce_prev = 1'b0;
  logic [7:0] rxq[$];
  bit         txq[$];

  ppm4_modem uut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
    .rx_sample(rx_sample), .rx_data(rx_data), .rx_data_valid(rx_data_valid),
    .rx_lock(rx_lock), .rx_err(rx_err)
  );

  always #5 clk = ~clk;

  task automatic chk(bit good, string req, int act, int exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Chip strobe: one clock in four, changed just after the edge.
  initial begin
    int k;
    k = 0;
    forever begin
      @(posedge clk);
      #1;
      chip_en = (k % 4 == 3);
      k++;
    end
  end

  task automatic do_reset();
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    rx_sample = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(tx_line == 1'b0, "R11 tx_line", tx_line, 0);
    chk(tx_ready == 1'b1, "R11 tx_ready", tx_ready, 1);
    chk(rx_lock == 1'b0, "R11 rx_lock", rx_lock, 0);
    chk(rx_err == 1'b0, "R11 rx_err", rx_err, 0);
    chk(rx_data_valid == 1'b0, "R11 rx_data_valid", rx_data_valid, 0);
    rst_n = 1'b1;
  endtask

  // Hold one chip value through the next chip edge; with noise the line
  // carries the opposite value on every non-chip edge.
  task automatic put_chip(bit b, bit noise);
    bit hit;
    forever begin
      rx_sample = (chip_en || !noise) ? b : ~b;
      hit = chip_en;
      @(posedge clk);
      #2;
      if (hit) break;
    end
  endtask

  task automatic put_sym(logic [3:0] m, bit noise);
    for (int c = 0; c < 4; c++) put_chip(m[c], noise);
  endtask

  task automatic put_byte(logic [7:0] b, bit noise);
    rxq.push_back(b);
    for (int i = 0; i < 4; i++) put_sym(4'b0001 << b[2*i +: 2], noise);
  endtask

  task automatic send_tx(logic [7:0] b);
    forever begin
      @(posedge clk);
      #4;
      if (tx_ready && (!chip_en || txq.size() != 0)) break;
    end
    tx_valid = 1'b1;
    tx_data  = b;
    @(posedge clk);
    #2;
    tx_valid = 1'b0;
    for (int i = 0; i < 4; i++)
      for (int c = 0; c < 4; c++) txq.push_back(b[2*i +: 2] == c[1:0]);
  endtask

  // Transmit monitor: one comparison per chip edge.
  initial begin
    forever begin
      @(negedge clk);
      if (ce_prev && rst_n) begin
        if (txq.size() != 0) begin
          bit e;
          e = txq.pop_front();
          chk(tx_line == e, "R2/R3 tx chip", tx_line, e);
        end else begin
          chk(tx_line == 1'b0, "R4 idle line", tx_line, 0);
        end
      end
      ce_prev = chip_en;
    end
  end

  // Receive monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (rx_data_valid) begin
        if (rxq.size() == 0) begin
          chk(1'b0, "R10 unexpected byte", rx_data, -1);
        end else begin
          logic [7:0] e;
          e = rxq.pop_front();
          chk(rx_data == e, "R10 rx byte", rx_data, e);
        end
      end
    end
  end

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();

    // Transmit: two bytes back to back, then one after an idle gap (R2 R3 R4).
    send_tx(8'hB4);
    chk(tx_ready == 1'b0, "R4 busy not ready", tx_ready, 0);
    send_tx(8'h1B);
    while (txq.size() != 0) @(posedge clk);
    repeat (20) @(posedge clk);
    send_tx(8'hE4);
    while (txq.size() != 0) @(posedge clk);
    repeat (10) @(posedge clk);
    #2;

    // Receive, aligned start.
    do_reset();
    put_sym(4'b0001, 1'b0);
    put_sym(4'b0010, 1'b0);
    put_sym(4'b0100, 1'b0);
    chk(rx_lock == 1'b0, "R7 no lock after 3", rx_lock, 0);
    put_sym(4'b1000, 1'b0);
    chk(rx_lock == 1'b1, "R7 lock after 4", rx_lock, 1);
    put_byte(8'hB4, 1'b1);               // R1 noise between chip edges
    rxq.push_back(8'hE4);                // R5 widened pulses
    put_sym(4'b0011, 1'b0);
    put_sym(4'b0110, 1'b0);
    put_sym(4'b1100, 1'b0);
    put_sym(4'b1000, 1'b0);
    chk(rx_err == 1'b0, "R6 no err on valid", rx_err, 0);
    put_sym(4'b0000, 1'b0);
    chk(rx_err == 1'b1, "R6 err on empty", rx_err, 1);
    chk(rx_lock == 1'b1, "R8 lock kept after one", rx_lock, 1);
    rxq.push_back(8'h1B);
    put_sym(4'b1000, 1'b0);
    put_sym(4'b0100, 1'b0);
    put_sym(4'b1010, 1'b0);
    chk(rx_err == 1'b1, "R6 err on split", rx_err, 1);
    put_sym(4'b0010, 1'b0);
    put_sym(4'b0001, 1'b0);
    chk(rx_lock == 1'b1, "R8 lock kept", rx_lock, 1);
    // Partial byte then loss of lock.
    put_sym(4'b0001, 1'b0);
    put_sym(4'b0001, 1'b0);
    put_sym(4'b0111, 1'b0);
    chk(rx_err == 1'b1, "R6 err on three", rx_err, 1);
    chk(rx_lock == 1'b1, "R8 lock after first miss", rx_lock, 1);
    put_sym(4'b1001, 1'b0);
    chk(rx_lock == 1'b0, "R8 lock lost", rx_lock, 0);
    for (int i = 0; i < 4; i++) put_sym(4'b0010, 1'b0);
    chk(rx_lock == 1'b1, "R7 relock", rx_lock, 1);
    put_byte(8'hFF, 1'b0);               // R10 partial byte discarded
    rx_sample = 1'b0;
    repeat (12) @(posedge clk);
    #2;
    chk(rxq.size() == 0, "R10 all bytes seen", rxq.size(), 0);

    // Receive, boundary hunting.
    do_reset();
    put_sym(4'b0000, 1'b0);
    chk(rx_err == 1'b0, "R6 quiet while unlocked", rx_err, 0);
    chk(rx_lock == 1'b0, "R9 unlocked", rx_lock, 0);
    rxq.push_back(8'h55);                // slipped window reads bit pair 01
    for (int i = 0; i < 3; i++) put_sym(4'b0001, 1'b0);
    chk(rx_lock == 1'b0, "R9 no early lock", rx_lock, 0);
    put_sym(4'b0001, 1'b0);
    chk(rx_lock == 1'b1, "R9 lock on slipped grid", rx_lock, 1);
    for (int i = 0; i < 4; i++) put_sym(4'b0001, 1'b0);
    rx_sample = 1'b0;
    repeat (12) @(posedge clk);
    #2;
    chk(rxq.size() == 0, "R9 slipped byte seen", rxq.size(), 0);
    chk(txq.size() == 0, "R3 tx chips all seen", txq.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule